// File: doc/BRIEF.md
# Multiword DMA Request Handshake Controller

This block is the device-side engine for multiword DMA on a parallel ATA bus. When the back end starts a transfer, it gives a direction and a word count. The controller then raises a DMA request whenever it can move the next word: data must be waiting in the transmit FIFO for device-to-host transfers, and there must be room in the receive FIFO for host-to-device transfers. It waits for the host's active-low acknowledge and then moves one 16-bit word on each read or write strobe. It drives the word to the host while the read strobe is low. It captures the host's word on the rising edge of the write strobe.

The request follows a strict handshake. Once raised, it is withdrawn only while acknowledge is asserted. That happens when the count runs out or the FIFO cannot take or supply the next word. The request is raised again when the FIFO recovers. The host may suspend a transfer by releasing acknowledge. The controller then holds its request, ignores strobes and resumes on the next acknowledge, and no word is lost. All host inputs arrive already synchronized to `clk`.

Top module: `mwdma_handshake`

## Requirements
- R1: While and after reset, `dmaReq`, `xferDone`, `hostDataOe`, `rxPush` and `txPop` are all 0.
- R2: After `xferStart` with a non-zero count, `dmaReq` rises on the second clock edge if the FIFO is ready. The FIFO is ready when `txEmpty`=0 with `xferRead`=1, or when `rxFull`=0 with `xferRead`=0. Otherwise `dmaReq` stays 0 until the FIFO becomes ready.
- R3: Once `dmaReq` is 1, it stays 1 in every cycle in which `dmaAckN` is 1.
- R4: In a host-to-device transfer with `dmaAckN`=0, each rising edge of `wrStrobeN` produces a one-cycle `rxPush` with `rxData` equal to `hostDataIn`.
- R5: In a device-to-host transfer with `dmaAckN`=0, `hostDataOe` is 1 and `hostDataOut` equals `txData` while `rdStrobeN` is 0. Each rising edge of `rdStrobeN` produces a one-cycle `txPop`.
- R6: After the programmed number of words, `dmaReq` falls, `xferDone` pulses for exactly one cycle, and further strobes move no data.
- R7: While `dmaAckN` is 1 during a transfer, `dmaReq` stays 1, strobes move no data, and the transfer resumes when `dmaAckN` returns to 0.
- R8: Between words, a full receive FIFO or an empty transmit FIFO makes `dmaReq` fall. `dmaReq` rises again once the FIFO recovers, and the words arrive complete and in order.
- R9: A strobe for the direction not in use moves no data and does not advance the count.
- R10: A start with a count of 0 gives one `xferDone` pulse on the next edge and never raises `dmaReq`.
- R11: `xferStart` is ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferStart | input | 1 | One-cycle start of a transfer |
| xferRead | input | 1 | 1 = device-to-host, 0 = host-to-device |
| xferWords | input | CNT_W | Word count of the transfer |
| dmaReq | output | 1 | DMA request to the host |
| dmaAckN | input | 1 | Host DMA acknowledge, active low |
| rdStrobeN | input | 1 | Host read strobe, active low |
| wrStrobeN | input | 1 | Host write strobe, active low |
| hostDataIn | input | DATA_W | Data bus value driven by the host |
| hostDataOut | output | DATA_W | Data bus value driven by the device |
| hostDataOe | output | 1 | Device drives the data bus |
| rxPush | output | 1 | Write one word into the receive FIFO |
| rxData | output | DATA_W | Word for the receive FIFO |
| rxFull | input | 1 | Receive FIFO has no room |
| txPop | output | 1 | Remove the head word of the transmit FIFO |
| txData | input | DATA_W | Head word of the transmit FIFO |
| txEmpty | input | 1 | Transmit FIFO has no word |
| xferDone | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The bench targets these corner cases:

- **Request with no acknowledge.** It holds the request for several cycles without acknowledging. A design that drops the request early would break the host handshake.
- **FIFO stalls.** It starves the FIFOs mid-transfer. A design that kept requesting would hand the host stale data or overwrite the receive FIFO, and the in-order word comparison catches this.
- **Suspension with stray strobes.** It suspends with stray strobes on the bus and sends strobes for the idle direction. A design that counted those strobes would finish early or push phantom words.
- **Zero count and restart while busy.** It issues a zero-count start and a second start during a transfer. Mishandling shows up as a missing or extra done pulse.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQUEST,
    ST_ACTIVE,
    ST_SUSPEND,
    ST_DONE
  } hsState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCount;
    logic xferEn;
    logic dirRead;
  } dpCtl_t;

endpackage

// File: rtl/mwdma_datapath.sv
module mwdma_datapath
  import mwdma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              dmaAckN,
  input  logic              rdStrobeN,
  input  logic              wrStrobeN,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic              rxPush,
  output logic [DATA_W-1:0] rxData,
  input  logic              rxFull,
  output logic              txPop,
  input  logic [DATA_W-1:0] txData,
  input  logic              txEmpty,
  input  logic [CNT_W-1:0]  xferWords,
  output logic              loadZero,
  output logic              readyNow,
  output logic              wordDone,
  output logic              lastWord,
  output logic              strobesIdle
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             rdPrevN;
  logic             wrPrevN;
  logic             rdRise;
  logic             wrRise;
  logic             moveOk;
  logic [CNT_W-1:0] wordsLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrevN <= 1'b1;
      wrPrevN <= 1'b1;
    end else begin
      rdPrevN <= rdStrobeN;
      wrPrevN <= wrStrobeN;
    end
  end

  assign rdRise = !rdPrevN && rdStrobeN;
  assign wrRise = !wrPrevN && wrStrobeN;
  assign moveOk = ctl.xferEn && !dmaAckN;

  // host-to-device: capture at the trailing edge of the write strobe
  assign rxPush = moveOk && !ctl.dirRead && wrRise;
  assign rxData = hostDataIn;

  // device-to-host: present FIFO head while read strobe is low
  assign txPop       = moveOk && ctl.dirRead && rdRise;
  assign hostDataOut = txData;
  assign hostDataOe  = moveOk && ctl.dirRead && !rdStrobeN;

  assign wordDone    = rxPush || txPop;
  assign readyNow    = ctl.dirRead ? !txEmpty : !rxFull;
  assign strobesIdle = rdStrobeN && wrStrobeN;
  assign loadZero    = (xferWords == '0);
  assign lastWord    = (wordsLeft == CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordsLeft <= '0;
    end else if (ctl.loadCount) begin
      wordsLeft <= xferWords;
    end else if (wordDone) begin
      wordsLeft <= wordsLeft - CNT_ONE;
    end
  end

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && !ctl.loadCount) |=> (wordsLeft == $past(wordsLeft) - CNT_ONE));

  assert_quiet_reset_R1: assert property (@(posedge clk)
    !rstN |=> (!rxPush && !txPop && !hostDataOe));

endmodule

// File: rtl/mwdma_ctrl.sv
module mwdma_ctrl
  import mwdma_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   xferStart,
  input  logic   xferRead,
  input  logic   dmaAckN,
  input  logic   loadZero,
  input  logic   readyNow,
  input  logic   wordDone,
  input  logic   lastWord,
  input  logic   strobesIdle,
  output dpCtl_t ctl,
  output logic   dmaReq,
  output logic   xferDone
);

  hsState_t state;
  hsState_t stateN;
  logic     reqQ;
  logic     reqN;
  logic     dirQ;
  logic     ackOn;

  assign ackOn = !dmaAckN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      reqQ  <= 1'b0;
      dirQ  <= 1'b0;
    end else begin
      state <= stateN;
      reqQ  <= reqN;
      if (state == ST_IDLE && xferStart) dirQ <= xferRead;
    end
  end

  always_comb begin
    stateN = state;
    reqN   = reqQ;
    unique case (state)
      ST_IDLE: begin
        reqN = 1'b0;
        if (xferStart) stateN = loadZero ? ST_DONE : ST_REQUEST;
      end
      ST_REQUEST: begin
        reqN = readyNow;
        if (reqQ && ackOn) stateN = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (wordDone) begin
          if (lastWord) begin
            stateN = ST_DONE;
            reqN   = 1'b0;
          end
        end else if (!ackOn) begin
          stateN = ST_SUSPEND;
        end else if (!readyNow && strobesIdle) begin
          stateN = ST_REQUEST;
          reqN   = 1'b0;
        end
      end
      ST_SUSPEND: begin
        if (ackOn) stateN = ST_ACTIVE;
      end
      ST_DONE: begin
        stateN = ST_IDLE;
        reqN   = 1'b0;
      end
      default: begin
        stateN = ST_IDLE;
        reqN   = 1'b0;
      end
    endcase
  end

  assign ctl.loadCount = (state == ST_IDLE) && xferStart;
  assign ctl.xferEn    = (state == ST_ACTIVE);
  assign ctl.dirRead   = dirQ;
  assign dmaReq        = reqQ;
  assign xferDone      = (state == ST_DONE);

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && dmaAckN) |=> dmaReq);

  assert_req_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaReq) |-> $past(readyNow));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  assert_suspend_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSPEND) |-> dmaReq);

  assert_zero_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && xferStart && loadZero) |=> (xferDone && !dmaReq));

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && xferStart && !wordDone && ackOn && readyNow) |=> (state == ST_ACTIVE));

endmodule

// File: rtl/mwdma_handshake.sv
module mwdma_handshake
  import mwdma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferStart,
  input  logic              xferRead,
  input  logic [CNT_W-1:0]  xferWords,
  output logic              dmaReq,
  input  logic              dmaAckN,
  input  logic              rdStrobeN,
  input  logic              wrStrobeN,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic              rxPush,
  output logic [DATA_W-1:0] rxData,
  input  logic              rxFull,
  output logic              txPop,
  input  logic [DATA_W-1:0] txData,
  input  logic              txEmpty,
  output logic              xferDone
);

  dpCtl_t ctl;
  logic   loadZero;
  logic   readyNow;
  logic   wordDone;
  logic   lastWord;
  logic   strobesIdle;

  mwdma_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .xferStart   (xferStart),
    .xferRead    (xferRead),
    .dmaAckN     (dmaAckN),
    .loadZero    (loadZero),
    .readyNow    (readyNow),
    .wordDone    (wordDone),
    .lastWord    (lastWord),
    .strobesIdle (strobesIdle),
    .ctl         (ctl),
    .dmaReq      (dmaReq),
    .xferDone    (xferDone)
  );

  mwdma_datapath #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .dmaAckN     (dmaAckN),
    .rdStrobeN   (rdStrobeN),
    .wrStrobeN   (wrStrobeN),
    .hostDataIn  (hostDataIn),
    .hostDataOut (hostDataOut),
    .hostDataOe  (hostDataOe),
    .rxPush      (rxPush),
    .rxData      (rxData),
    .rxFull      (rxFull),
    .txPop       (txPop),
    .txData      (txData),
    .txEmpty     (txEmpty),
    .xferWords   (xferWords),
    .loadZero    (loadZero),
    .readyNow    (readyNow),
    .wordDone    (wordDone),
    .lastWord    (lastWord),
    .strobesIdle (strobesIdle)
  );

endmodule

// File: tb/mwdma_handshake_tb.sv
module mwdma_handshake_tb_top;

  localparam int DATA_W = 16;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              xferStart = 1'b0;
  logic              xferRead = 1'b0;
  logic [CNT_W-1:0]  xferWords = '0;
  logic              dmaReq;
  logic              dmaAckN = 1'b1;
  logic              rdStrobeN = 1'b1;
  logic              wrStrobeN = 1'b1;
  logic [DATA_W-1:0] hostDataIn = '0;
  logic [DATA_W-1:0] hostDataOut;
  logic              hostDataOe;
  logic              rxPush;
  logic [DATA_W-1:0] rxData;
  logic              rxFull;
  logic              txPop;
  logic [DATA_W-1:0] txData;
  logic              txEmpty;
  logic              xferDone;

  always #2.5 clk = ~clk;

  int cmpCnt = 0;
  int errCnt = 0;
  int pushCnt = 0;
  int popCnt = 0;
  int doneCnt = 0;
  int hostWrIdx = 0;
  int hostRdIdx = 0;
  int txGiven = 0;     // written by the main sequence only
  int txRefill = 0;    // written by the back-end model only
  int rxGiven = 0;
  int rxDrained = 0;
  int autoFeed = 0;
  int feedWait = 0;
  int drainWait = 0;
  bit summaryDone = 0;

  function automatic logic [15:0] txWord(input int i);
    return 16'((i * 977) ^ 32'h5a5a);
  endfunction

  function automatic logic [15:0] hostWord(input int i);
    return 16'((i * 613) + 32'h1234);
  endfunction

  assign txEmpty = (txGiven + txRefill - popCnt) <= 0;
  assign rxFull  = (rxGiven + rxDrained - pushCnt) <= 0;
  assign txData  = txWord(popCnt);

  mwdma_handshake #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .xferStart(xferStart), .xferRead(xferRead),
    .xferWords(xferWords), .dmaReq(dmaReq), .dmaAckN(dmaAckN),
    .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe), .rxPush(rxPush),
    .rxData(rxData), .rxFull(rxFull), .txPop(txPop), .txData(txData),
    .txEmpty(txEmpty), .xferDone(xferDone)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    cmpCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // back-end model and event counters, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (rxPush) begin
        check(rxData == hostWord(pushCnt), "R4 pushed word", rxData, hostWord(pushCnt));
        pushCnt++;
      end
      if (txPop) popCnt++;
      if (xferDone) doneCnt++;
      if (autoFeed != 0 && (txGiven + txRefill - popCnt) <= 0) begin
        feedWait++;
        if (feedWait > int'($urandom_range(6, 2))) begin
          txRefill += int'($urandom_range(3, 1));
          feedWait = 0;
        end
      end
      if (autoFeed != 0 && (rxGiven + rxDrained - pushCnt) <= 0) begin
        drainWait++;
        if (drainWait > int'($urandom_range(6, 2))) begin
          rxDrained += int'($urandom_range(2, 1));
          drainWait = 0;
        end
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic startXfer(input bit rd, input int n);
    tick(1);
    xferStart = 1'b1;
    xferRead  = rd;
    xferWords = CNT_W'(n);
    tick(1);
    xferStart = 1'b0;
  endtask

  task automatic waitReq(input string tag);
    int t;
    t = 0;
    @(negedge clk);
    while (!dmaReq && t < 400) begin
      @(negedge clk);
      t++;
    end
    check(dmaReq == 1'b1, tag, dmaReq, 1);
    tick(1);
  endtask

  task automatic writeWord();
    wrStrobeN  = 1'b0;
    hostDataIn = hostWord(hostWrIdx);
    hostWrIdx++;
    tick(2);
    wrStrobeN = 1'b1;
    tick(2);
  endtask

  task automatic readWord();
    rdStrobeN = 1'b0;
    @(negedge clk);
    check(hostDataOe == 1'b1, "R5 bus driven", hostDataOe, 1);
    check(hostDataOut == txWord(hostRdIdx), "R5 read data", hostDataOut, txWord(hostRdIdx));
    hostRdIdx++;
    tick(2);
    rdStrobeN = 1'b1;
    tick(2);
  endtask

  // host side of one transfer; suspends at random when allowed
  task automatic hostXfer(input bit rd, input int n, input bit mayPause);
    bit acked;
    int got;
    int p0;
    int q0;
    acked = 0;
    got = 0;
    while (got < n) begin
      if (!acked) begin
        waitReq("R8 request re-raised");
        dmaAckN = 1'b0;
        tick(2);
        acked = 1;
      end
      if (mayPause && $urandom_range(3, 0) == 0) begin
        dmaAckN = 1'b1;
        p0 = pushCnt;
        q0 = popCnt;
        tick(1);
        rdStrobeN = 1'b0;
        wrStrobeN = 1'b0;
        tick(2);
        rdStrobeN = 1'b1;
        wrStrobeN = 1'b1;
        tick(2);
        @(negedge clk);
        check(dmaReq == 1'b1, "R7 request held in pause", dmaReq, 1);
        check(pushCnt + popCnt == p0 + q0, "R7 strobes ignored", pushCnt + popCnt, p0 + q0);
        tick(1);
        dmaAckN = 1'b0;
        tick(2);
      end
      if (rd) readWord(); else writeWord();
      got++;
      @(negedge clk);
      if (!dmaReq) begin
        tick(1);
        dmaAckN = 1'b1;
        acked = 0;
      end else begin
        tick(1);
      end
    end
    dmaAckN = 1'b1;
    tick(3);
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errCnt++;
    $display("FAIL all: watchdog expired actual=hang expected=finish");
    summary();
    $finish;
  end

  initial begin
    int d0, p0, q0;
    void'($urandom(32'd4242));
    tick(3);
    @(negedge clk);
    check(!dmaReq && !xferDone && !hostDataOe && !rxPush && !txPop, "R1 reset quiet",
          {dmaReq, xferDone, hostDataOe, rxPush, txPop}, 0);
    rstN = 1'b1;
    tick(2);
    @(negedge clk);
    check(dmaReq == 1'b0, "R1 idle after reset", dmaReq, 0);

    // R2 timing and R3 hold without acknowledge
    txGiven = 4;
    d0 = doneCnt;
    startXfer(1'b1, 2);
    @(negedge clk);
    check(dmaReq == 1'b0, "R2 first edge", dmaReq, 0);
    @(negedge clk);
    check(dmaReq == 1'b1, "R2 second edge", dmaReq, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(dmaReq == 1'b1, "R3 held without ack", dmaReq, 1);
    end
    hostXfer(1'b1, 2, 1'b0);
    check(doneCnt == d0 + 1, "R6 one done pulse", doneCnt, d0 + 1);
    check(dmaReq == 1'b0, "R6 request dropped", dmaReq, 0);

    // R2 not ready: empty FIFO holds the request low
    txGiven = popCnt;
    startXfer(1'b1, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(dmaReq == 1'b0, "R2 no request when empty", dmaReq, 0);
    end
    txGiven = popCnt + 1;
    hostXfer(1'b1, 1, 1'b0);
    check(popCnt == hostRdIdx, "R5 pops match reads", popCnt, hostRdIdx);

    // R8 read stall mid-transfer
    txGiven = popCnt + 2;
    q0 = popCnt;
    startXfer(1'b1, 3);
    fork
      hostXfer(1'b1, 3, 1'b0);
      begin
        wait (popCnt == q0 + 2);
        repeat (4) @(negedge clk);
        check(dmaReq == 1'b0, "R8 read stall drops request", dmaReq, 0);
        txGiven = txGiven + 1;
      end
    join
    check(popCnt == q0 + 3, "R8 all read words moved", popCnt, q0 + 3);

    // R8 write stall mid-transfer
    rxGiven = pushCnt + 1;
    p0 = pushCnt;
    startXfer(1'b0, 2);
    fork
      hostXfer(1'b0, 2, 1'b0);
      begin
        wait (pushCnt == p0 + 1);
        repeat (4) @(negedge clk);
        check(dmaReq == 1'b0, "R8 write stall drops request", dmaReq, 0);
        rxGiven = rxGiven + 1;
      end
    join
    check(pushCnt == p0 + 2, "R8 all write words moved", pushCnt, p0 + 2);

    // R10 zero count
    d0 = doneCnt;
    tick(1);
    xferStart = 1'b1;
    xferRead  = 1'b0;
    xferWords = '0;
    tick(1);
    xferStart = 1'b0;
    @(negedge clk);
    check(xferDone == 1'b1 && dmaReq == 1'b0, "R10 immediate done", {xferDone, dmaReq}, 2'b10);
    @(negedge clk);
    check(xferDone == 1'b0 && dmaReq == 1'b0, "R10 single pulse", {xferDone, dmaReq}, 2'b00);

    // R11 second start while busy
    rxGiven = pushCnt + 8;
    txGiven = popCnt + 8;
    p0 = pushCnt;
    q0 = popCnt;
    d0 = doneCnt;
    startXfer(1'b0, 2);
    startXfer(1'b1, 5);
    hostXfer(1'b0, 2, 1'b0);
    check(doneCnt == d0 + 1, "R11 done after first count", doneCnt, d0 + 1);
    check(pushCnt == p0 + 2 && popCnt == q0, "R11 first direction kept", pushCnt - p0, 2);

    // R9 wrong-direction strobe during a read transfer
    p0 = pushCnt;
    q0 = popCnt;
    d0 = doneCnt;
    startXfer(1'b1, 1);
    waitReq("R9 request");
    dmaAckN = 1'b0;
    tick(2);
    writeWord();
    hostWrIdx--;
    @(negedge clk);
    check(pushCnt == p0, "R9 write strobe ignored", pushCnt, p0);
    check(dmaReq == 1'b1 && doneCnt == d0, "R9 count not advanced", doneCnt, d0);
    tick(1);
    readWord();
    @(negedge clk);
    check(doneCnt == d0 + 1, "R6 done after read", doneCnt, d0 + 1);
    tick(1);
    wrStrobeN = 1'b0;
    tick(2);
    wrStrobeN = 1'b1;
    tick(2);
    @(negedge clk);
    check(pushCnt == p0 && popCnt == q0 + 1, "R6 no move after done", pushCnt + popCnt, p0 + q0 + 1);
    dmaAckN = 1'b1;

    // random transfers with pauses and back-end stalls
    autoFeed = 1;
    for (int k = 0; k < 14; k++) begin
      bit rd;
      int n;
      rd = 1'($urandom_range(1, 0));
      n  = int'($urandom_range(8, 1));
      p0 = pushCnt;
      q0 = popCnt;
      d0 = doneCnt;
      startXfer(rd, n);
      hostXfer(rd, n, 1'b1);
      check(doneCnt == d0 + 1, "R6 random done", doneCnt, d0 + 1);
      if (rd) check(popCnt == q0 + n && pushCnt == p0, "R5 random read count", popCnt - q0, n);
      else    check(pushCnt == p0 + n && popCnt == q0, "R4 random write count", pushCnt - p0, n);
    end
    check(pushCnt == hostWrIdx, "R4 all host words pushed", pushCnt, hostWrIdx);

    summary();
    $finish;
  end

endmodule